// File: doc/BRIEF.md
# Sample Load Buffer with Tail-Gated Handoff

This block sits between an analog-to-digital converter and a recirculating word memory. It captures one 6-bit sample each time the converter signals that a conversion is done, and holds it in a one-word load buffer. It then passes the word to the memory as a single-cycle write pulse. The memory circulates its words on a fixed-length loop. The buffer is emptied only in the cycle right after the loop's tail position, so each new sample replaces the oldest word in the loop.

Everything except the conversion-done input runs on the word clock. That input arrives asynchronously. It passes through a synchronizer, and its rising edge is treated as the load request. The block tracks the loop position itself and brings out a tail marker. It also produces the sample-rate strobe that starts conversions, with the divisor chosen by a range-select input. The two ranges give sample rates of three times the highest frequency of interest.

If a load request and an unload fall in the same cycle, the two are separated. The unload goes first and the load follows one cycle later. If a load request arrives while the buffer is still full, the block flags an overrun and keeps the held word.

Top module: `sample_load_buffer`

## Requirements
- R1: Out of reset, `buf_full`, `mem_load`, `overrun`, `tail` and `sample_strobe` are all 0.
- R2: `sample_strobe` is a one-cycle pulse. With `range_wide`=0 it repeats every DIV_NARROW (8000) cycles, with the first pulse on the 8000th clock edge after reset. With `range_wide`=1 it repeats every DIV_WIDE (800) cycles.
- R3: `tail` is high for exactly one cycle in every DEPTH (600). It is high after clock edge k (counting from the first edge after reset) exactly when k mod DEPTH = DEPTH-1.
- R4: Suppose `eoc` is first sampled high at edge n and edge n+2 does not see `tail` high. Then `adc_data` is captured at edge n+2 and `buf_full` is 1 after that edge.
- R5: If `buf_full` is 1 in a cycle where `tail` is 1, then after the next edge `mem_load` is 1 for exactly one cycle, `mem_word` equals the held sample, and `buf_full` is 0. `mem_load` is never 1 at any other time.
- R6: A load request whose capture edge sees `tail` high is deferred by one cycle. The load and the unload never take effect at the same edge. A full buffer at such a tail is unloaded first, then refilled with the new sample without an overrun.
- R7: A load request that finds `buf_full`=1 outside a tail cycle pulses `overrun` for one cycle at the capture edge. The held sample is kept, and the new sample is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| range_wide | input | 1 | 0 selects the narrow range (divide by DIV_NARROW), 1 the wide range (divide by DIV_WIDE) |
| eoc | input | 1 | Asynchronous conversion-done flag; its rising edge requests a load |
| adc_data | input | SAMPLE_W | Converter output word, stable from `eoc` rise until captured |
| sample_strobe | output | 1 | One-cycle pulse at the selected sample rate |
| tail | output | 1 | One-cycle marker at the last word position of the loop |
| mem_load | output | 1 | One-cycle write pulse to the memory, the cycle after the tail |
| mem_word | output | SAMPLE_W | Word delivered to the memory with `mem_load` |
| buf_full | output | 1 | Load buffer holds a word not yet delivered |
| overrun | output | 1 | One-cycle pulse when a sample is dropped because the buffer is full |

## Verification
The two functions that can meet in one cycle are the capture of a new sample and the unload of the buffer at the tail. The bench provokes this by raising `eoc` three edges before a tail boundary, so that the synchronized edge lands exactly on the tail cycle. It does this once with the buffer empty and once with it full. A queue scoreboard then judges the outcome. It checks that the old word comes out at the tail, that `buf_full` drops and rises again one cycle later with the new word and no overrun, and that the deferred word reaches the memory at the next tail.

// File: rtl/slb_pkg.sv
package slb_pkg;
  typedef enum logic {RANGE_NARROW = 1'b0, RANGE_WIDE = 1'b1} range_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/slb_eoc_sync.sv
module slb_eoc_sync (
  input  logic clk,
  input  logic rst,
  input  logic eoc_async,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= eoc_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

  // R4: a synchronized edge never repeats in consecutive cycles
  a_r4_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/slb_rate_gen.sv
module slb_rate_gen #(
  parameter int DIV_NARROW = 8000,
  parameter int DIV_WIDE   = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic range_wide,
  output logic strobe
);
  import slb_pkg::*;
  localparam int DMAX = max_int(DIV_NARROW, DIV_WIDE);
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  range_e        sel;

  assign sel  = range_e'(range_wide);
  assign last = (sel == RANGE_WIDE) ? CW'(DIV_WIDE - 1) : CW'(DIV_NARROW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (cnt >= last) begin
      cnt    <= '0;
      strobe <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      strobe <= 1'b0;
    end
  end

  // R2: the strobe is a single-cycle pulse
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/slb_tail_track.sv
module slb_tail_track #(
  parameter int DEPTH = 600
) (
  input  logic clk,
  input  logic rst,
  output logic tail
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      tail <= 1'b0;
    end else begin
      pos  <= (pos == PW'(DEPTH - 1)) ? '0 : pos + 1'b1;
      tail <= (pos == PW'(DEPTH - 2));
    end
  end

  // R3: the tail marker lasts a single cycle
  a_r3_tail_single: assert property (@(posedge clk) disable iff (rst)
    tail |=> !tail);
endmodule

// File: rtl/slb_load_ctrl.sv
module slb_load_ctrl #(
  parameter int SAMPLE_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                tail,
  output logic                buf_full,
  output logic                mem_load,
  output logic [SAMPLE_W-1:0] mem_word,
  output logic                overrun
);
  logic [SAMPLE_W-1:0] hold_q;
  logic [SAMPLE_W-1:0] pend_data;
  logic                pend_q;
  logic                req;

  assign req = rise | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      pend_data <= '0;
      pend_q    <= 1'b0;
      buf_full  <= 1'b0;
      mem_load  <= 1'b0;
      mem_word  <= '0;
      overrun   <= 1'b0;
    end else begin
      mem_load <= 1'b0;
      overrun  <= 1'b0;
      if (tail) begin
        // unload slot: any new load waits one cycle
        if (buf_full) begin
          mem_load <= 1'b1;
          mem_word <= hold_q;
          buf_full <= 1'b0;
        end
        if (rise) begin
          pend_q    <= 1'b1;
          pend_data <= adc_data;
        end
      end else begin
        pend_q <= 1'b0;
        if (req) begin
          if (buf_full) begin
            overrun <= 1'b1;
          end else begin
            buf_full <= 1'b1;
            hold_q   <= pend_q ? pend_data : adc_data;
          end
        end
      end
    end
  end

  // R5: a memory write only follows a tail cycle
  a_r5_load_after_tail: assert property (@(posedge clk) disable iff (rst)
    mem_load |-> $past(tail));
  // R5: the buffer is empty once its word is delivered
  a_r5_empty_after_unload: assert property (@(posedge clk) disable iff (rst)
    mem_load |-> !buf_full);
  // R6: a fill never lands on the same edge as an unload
  a_r6_no_coincide: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> !mem_load);
  // R7: overrun only while a word is held, and that word is unchanged
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    overrun |-> (buf_full && $past(buf_full) && $stable(hold_q)));
endmodule

// File: rtl/sample_load_buffer.sv
module sample_load_buffer #(
  parameter int SAMPLE_W   = 6,
  parameter int DEPTH      = 600,
  parameter int DIV_NARROW = 8000,
  parameter int DIV_WIDE   = 800
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                range_wide,
  input  logic                eoc,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                sample_strobe,
  output logic                tail,
  output logic                mem_load,
  output logic [SAMPLE_W-1:0] mem_word,
  output logic                buf_full,
  output logic                overrun
);
  logic eoc_rise;

  slb_eoc_sync u_sync (
    .clk(clk), .rst(rst), .eoc_async(eoc), .rise(eoc_rise)
  );

  slb_rate_gen #(.DIV_NARROW(DIV_NARROW), .DIV_WIDE(DIV_WIDE)) u_rate (
    .clk(clk), .rst(rst), .range_wide(range_wide), .strobe(sample_strobe)
  );

  slb_tail_track #(.DEPTH(DEPTH)) u_tail (
    .clk(clk), .rst(rst), .tail(tail)
  );

  slb_load_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk(clk), .rst(rst), .rise(eoc_rise), .adc_data(adc_data), .tail(tail),
    .buf_full(buf_full), .mem_load(mem_load), .mem_word(mem_word),
    .overrun(overrun)
  );

  // R1: outputs idle in the first cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!buf_full && !mem_load && !overrun && !tail));
endmodule

// File: tb/sample_load_buffer_test.sv
module sample_load_buffer_test;
  localparam int D  = 600;
  localparam int DN = 8000;
  localparam int DW = 800;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       range_wide = 1'b0;
  logic       eoc = 1'b0;
  logic [5:0] adc_data = '0;
  logic       sample_strobe, tail, mem_load, buf_full, overrun;
  logic [5:0] mem_word;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [5:0] expq[$];
  int  prev_strobe = 0;
  bit  skip_strobe = 1'b0;
  int  exp_period = DN;

  sample_load_buffer #(.SAMPLE_W(6), .DEPTH(D), .DIV_NARROW(DN), .DIV_WIDE(DW)) uut (
    .clk(clk), .rst(rst), .range_wide(range_wide), .eoc(eoc), .adc_data(adc_data),
    .sample_strobe(sample_strobe), .tail(tail), .mem_load(mem_load),
    .mem_word(mem_word), .buf_full(buf_full), .overrun(overrun)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    while (cyc != k) @(negedge clk);
  endtask

  // driver: raise eoc with a sample at cycle k, push it if it should reach memory
  task automatic start_conv(input int k, input logic [5:0] d, input bit keep);
    wait_cyc(k);
    adc_data = d;
    eoc = 1'b1;
    if (keep) expq.push_back(d);
    fork
      begin
        repeat (4) @(negedge clk);
        eoc = 1'b0;
      end
    join_none
  endtask

  // monitors
  always @(negedge clk) begin
    if (!rst) begin
      if (tail !== ((cyc % D) == D - 1))
        chk(1'b0, "R3 tail position", int'(tail), int'((cyc % D) == D - 1));
      else if (tail)
        chk(1'b1, "R3", 1, 1);
      if (sample_strobe) begin
        if (!skip_strobe)
          chk(cyc - prev_strobe == exp_period, "R2 strobe period", cyc - prev_strobe, exp_period);
        prev_strobe = cyc;
        skip_strobe = 1'b0;
      end
      if (mem_load) begin
        chk((cyc % D) == 0, "R5 unload slot", cyc % D, 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected word", int'(mem_word), -1);
        end else begin
          logic [5:0] e;
          e = expq.pop_front();
          chk(mem_word == e, "R5 unloaded word", int'(mem_word), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!buf_full && !mem_load && !overrun && !tail && !sample_strobe, "R1 reset state",
        int'({buf_full, mem_load, overrun, tail, sample_strobe}), 0);

    // R4 plain load, R5 unload at next tail
    start_conv(10, 6'h2A, 1'b1);
    wait_cyc(12);
    chk(buf_full == 1'b0, "R4 not yet loaded", int'(buf_full), 0);
    wait_cyc(13);
    chk(buf_full == 1'b1, "R4 loaded", int'(buf_full), 1);
    wait_cyc(600);
    chk(mem_load == 1'b1, "R5 write pulse", int'(mem_load), 1);
    chk(buf_full == 1'b0, "R5 buffer emptied", int'(buf_full), 0);
    wait_cyc(601);
    chk(mem_load == 1'b0, "R5 pulse single", int'(mem_load), 0);

    // R7 overrun keeps first sample
    start_conv(700, 6'h15, 1'b1);
    start_conv(720, 6'h3F, 1'b0);
    wait_cyc(722);
    chk(overrun == 1'b0, "R7 no early overrun", int'(overrun), 0);
    wait_cyc(723);
    chk(overrun == 1'b1, "R7 overrun pulse", int'(overrun), 1);
    wait_cyc(724);
    chk(overrun == 1'b0, "R7 overrun single", int'(overrun), 0);

    // R6 collision with empty buffer: load deferred one cycle
    start_conv(1797, 6'h07, 1'b1);
    wait_cyc(1800);
    chk(buf_full == 1'b0 && mem_load == 1'b0, "R6 empty deferred",
        int'({buf_full, mem_load}), 0);
    wait_cyc(1801);
    chk(buf_full == 1'b1, "R6 deferred load", int'(buf_full), 1);

    // R6 collision with full buffer: unload first, then refill, no overrun
    start_conv(2500, 6'h31, 1'b1);
    start_conv(2997, 6'h0C, 1'b1);
    wait_cyc(3000);
    chk(mem_load == 1'b1 && buf_full == 1'b0, "R6 unload before refill",
        int'({mem_load, buf_full}), 2);
    wait_cyc(3001);
    chk(buf_full == 1'b1 && overrun == 1'b0, "R6 refill without overrun",
        int'({buf_full, overrun}), 2);

    // R2 switch to wide range
    wait_cyc(20000);
    range_wide = 1'b1;
    exp_period = DW;
    skip_strobe = 1'b1;
    wait_cyc(24000);
    chk(expq.size() == 0, "R5 all words delivered", expq.size(), 0);
    chk(prev_strobe > 22000, "R2 wide strobes seen", prev_strobe, 22001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule